// File: doc/BRIEF.md
# SECDED Check-Bit Generator and Decoder

This block checks one 64-bit data word read back from memory together with the 8 check bits stored beside it. It recomputes the check byte from the data through a fixed matrix of eight 64-bit parity masks. It XORs the result with the stored byte to form an 8-bit syndrome. From the syndrome it decides whether the word is clean, carries one flipped data bit, carries one flipped check bit, or cannot be repaired. It then drives out the repaired data word and check byte.

The block sits on a read return path. A parameter picks one of two forms. The first is a purely combinational decoder. The second, the default, registers the result once, with a valid flag that lines up with the registered result.

Top module: `secdedDecoder`

## Requirements
- R1: Check bit i is the XOR of the data bits selected by mask i (bit k of the mask selects data bit k). The masks, as bits 63:32 / 31:0, are: i=0 F00FE11E/C33C0FF7, i=1 00FF00FF/00FFF0FF, i=2 0F0F0F0F/0F0FFF00, i=3 11113333/7777000F, i=4 22224444/8888222F, i=5 44448888/FFFF4441, i=6 8888FFFF/11118882, i=7 FFFF1111/22221114. The syndrome is the recomputed byte XOR the stored byte.
- R2: The column of data bit b is the byte whose bit i is bit b of mask i. If the syndrome equals a column, the lowest such b is reported. In that case outStatus is 1, outIndex is b, outData is the input with bit b inverted, and outCheck equals the input check byte.
- R3: If no column matches and the syndrome has exactly one bit set, at position j, then outStatus is 2 and outIndex is j. outCheck is the input check byte with bit j inverted, and outData equals the input data.
- R4: A zero syndrome gives outStatus 0 and outIndex 0, and the data and check byte pass through unchanged.
- R5: A nonzero syndrome that matches no column and has two or more bits set gives outStatus 3 and outIndex 0, and the data and check byte pass through unchanged.
- R6: Any two-bit flip of a valid codeword is reported with outStatus 3, unless its syndrome equals a data column. In that case it is reported as in R2.
- R7: With OutReg=1 (default), all outputs appear one clock after the inputs, and outValid is inValid delayed by one clock. During reset outValid and outStatus are 0. With OutReg=0 the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| inValid | input | 1 | Input word is meaningful |
| inData | input | 64 | Data word as read |
| inCheck | input | 8 | Stored check byte as read |
| outValid | output | 1 | Result is meaningful |
| outData | output | 64 | Corrected data word |
| outCheck | output | 8 | Corrected check byte |
| outStatus | output | 2 | 0 clean, 1 data-bit error, 2 check-bit error, 3 uncorrectable |
| outIndex | output | 6 | Faulty bit index for status 1 or 2, else 0 |

## Verification
The properties assume that inData and inCheck hold known values whenever inValid is high. They also assume that, in the registered form, the inputs seen at a clock edge are the ones the result belongs to. The stimulus changes the inputs only on falling edges and always drives fully defined words. Each vector is built from a codeword formed by the bench's own encoder, which may then have one or two bits flipped, or from a raw random check byte. This keeps every syndrome class reachable.

// File: rtl/secdedPkg.sv
package secdedPkg;
  localparam int DataW = 64;
  localparam int ChkW  = 8;
  localparam int IdxW  = $clog2(DataW);

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_DATA  = 2'd1,
    ST_CHECK = 2'd2,
    ST_FATAL = 2'd3
  } status_e;

  // strobes from classification logic to the datapath
  typedef struct packed {
    logic              flipData;
    logic              flipCheck;
    logic [IdxW-1:0]   idx;
    status_e           status;
  } strobe_t;

  function automatic logic [DataW-1:0] rowMask(input int i);
    case (i)
      0:       rowMask = 64'hF00FE11E_C33C0FF7;
      1:       rowMask = 64'h00FF00FF_00FFF0FF;
      2:       rowMask = 64'h0F0F0F0F_0F0FFF00;
      3:       rowMask = 64'h11113333_7777000F;
      4:       rowMask = 64'h22224444_8888222F;
      5:       rowMask = 64'h44448888_FFFF4441;
      6:       rowMask = 64'h8888FFFF_11118882;
      default: rowMask = 64'hFFFF1111_22221114;
    endcase
  endfunction

  function automatic logic [ChkW-1:0] column(input int b);
    logic [ChkW-1:0] c;
    for (int i = 0; i < ChkW; i++) begin
      logic [DataW-1:0] m;
      m = rowMask(i);
      c[i] = m[b];
    end
    return c;
  endfunction
endpackage

// File: rtl/secdedDatapath.sv
module secdedDatapath
  import secdedPkg::*;
(
  input  logic [DataW-1:0] dataIn,
  input  logic [ChkW-1:0]  checkIn,
  input  strobe_t          strobe,
  output logic [ChkW-1:0]  syndrome,
  output logic [DataW-1:0] dataFixed,
  output logic [ChkW-1:0]  checkFixed
);
  logic [ChkW-1:0] fresh;

  for (genvar g = 0; g < ChkW; g++) begin : g_row
    localparam logic [DataW-1:0] Mask = rowMask(g);
    assign fresh[g] = ^(dataIn & Mask);
  end

  assign syndrome = fresh ^ checkIn;

  logic [DataW-1:0] dataFlip;
  logic [ChkW-1:0]  checkFlip;

  always_comb begin
    dataFlip  = '0;
    checkFlip = '0;
    if (strobe.flipData)  dataFlip[strobe.idx] = 1'b1;
    if (strobe.flipCheck) checkFlip[strobe.idx[$clog2(ChkW)-1:0]] = 1'b1;
  end

  assign dataFixed  = dataIn ^ dataFlip;
  assign checkFixed = checkIn ^ checkFlip;
endmodule

// File: rtl/secdedControl.sv
module secdedControl
  import secdedPkg::*;
(
  input  logic [ChkW-1:0] syndrome,
  output strobe_t         strobe
);
  logic            colHit;
  logic [IdxW-1:0] colIdx;
  logic            bitHit;
  logic [IdxW-1:0] bitIdx;

  // data columns searched from bit 0 upward, first match wins
  always_comb begin
    colHit = 1'b0;
    colIdx = '0;
    for (int b = 0; b < DataW; b++) begin
      if (!colHit && syndrome == column(b)) begin
        colHit = 1'b1;
        colIdx = IdxW'(b);
      end
    end
  end

  always_comb begin
    bitHit = 1'b0;
    bitIdx = '0;
    for (int j = 0; j < ChkW; j++) begin
      if (!bitHit && syndrome[j]) begin
        bitHit = 1'b1;
        bitIdx = IdxW'(j);
      end
    end
  end

  always_comb begin
    strobe = '{flipData: 1'b0, flipCheck: 1'b0, idx: '0, status: ST_CLEAN};
    if (syndrome == '0) begin
      strobe.status = ST_CLEAN;
    end else if (colHit) begin
      strobe.status   = ST_DATA;
      strobe.flipData = 1'b1;
      strobe.idx      = colIdx;
    end else if ($onehot(syndrome)) begin
      strobe.status    = ST_CHECK;
      strobe.flipCheck = bitHit;
      strobe.idx       = bitIdx;
    end else begin
      strobe.status = ST_FATAL;
    end
  end
endmodule

// File: rtl/secdedDecoder.sv
module secdedDecoder
  import secdedPkg::*;
#(
  parameter bit OutReg = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [DataW-1:0] inData,
  input  logic [ChkW-1:0]  inCheck,
  output logic             outValid,
  output logic [DataW-1:0] outData,
  output logic [ChkW-1:0]  outCheck,
  output logic [1:0]       outStatus,
  output logic [IdxW-1:0]  outIndex
);
  logic [ChkW-1:0]  syndrome;
  strobe_t          strobe;
  logic [DataW-1:0] dataFixed;
  logic [ChkW-1:0]  checkFixed;

  secdedDatapath u_dp (
    .dataIn    (inData),
    .checkIn   (inCheck),
    .strobe    (strobe),
    .syndrome  (syndrome),
    .dataFixed (dataFixed),
    .checkFixed(checkFixed)
  );

  secdedControl u_ctl (
    .syndrome(syndrome),
    .strobe  (strobe)
  );

  if (OutReg) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outValid  <= 1'b0;
        outData   <= '0;
        outCheck  <= '0;
        outStatus <= ST_CLEAN;
        outIndex  <= '0;
      end else begin
        outValid  <= inValid;
        outData   <= dataFixed;
        outCheck  <= checkFixed;
        outStatus <= strobe.status;
        outIndex  <= strobe.idx;
      end
    end
  end else begin : g_comb
    assign outValid  = inValid;
    assign outData   = dataFixed;
    assign outCheck  = checkFixed;
    assign outStatus = strobe.status;
    assign outIndex  = strobe.idx;
  end
endmodule

// File: rtl/secdedDecoderProps.sv
module secdedDecoderProps
  import secdedPkg::*;
#(
  parameter bit OutReg = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [DataW-1:0] inData,
  input logic [ChkW-1:0]  inCheck,
  input logic             outValid,
  input logic [DataW-1:0] outData,
  input logic [ChkW-1:0]  outCheck,
  input logic [1:0]       outStatus,
  input logic [IdxW-1:0]  outIndex
);
  logic [DataW-1:0] refData;
  logic [ChkW-1:0]  refCheck;

  if (OutReg) begin : g_ref
    always_ff @(posedge clk) begin
      refData  <= inData;
      refCheck <= inCheck;
    end
    // R7: valid is the input valid one clock later
    p_valid_delay_r7: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> outValid == $past(inValid));
  end else begin : g_noref
    assign refData  = inData;
    assign refCheck = inCheck;
  end

  // R4: clean word passes through untouched
  p_clean_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == 2'd0) |-> (outData == refData && outCheck == refCheck && outIndex == '0));

  // R2: data repair flips exactly one data bit, at the reported index
  p_data_fix_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == 2'd1) |->
      ($countones(outData ^ refData) == 1 && (outData ^ refData) == (64'd1 << outIndex) && outCheck == refCheck));

  // R3: check repair flips exactly one check bit, index below the byte width
  p_check_fix_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == 2'd2) |->
      ($countones(outCheck ^ refCheck) == 1 && outIndex < IdxW'(ChkW) && outData == refData));

  // R5: uncorrectable word passes through untouched
  p_fatal_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == 2'd3) |-> (outData == refData && outCheck == refCheck && outIndex == '0));
endmodule

bind secdedDecoder secdedDecoderProps #(.OutReg(OutReg)) u_props (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inCheck(inCheck),
  .outValid(outValid), .outData(outData), .outCheck(outCheck),
  .outStatus(outStatus), .outIndex(outIndex)
);

// File: tb/secdedDecoder_test.sv
module secdedDecoder_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [63:0] inData;
  logic [7:0]  inCheck;
  logic        outValid;
  logic [63:0] outData;
  logic [7:0]  outCheck;
  logic [1:0]  outStatus;
  logic [5:0]  outIndex;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  secdedDecoder uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inCheck(inCheck),
    .outValid(outValid), .outData(outData), .outCheck(outCheck),
    .outStatus(outStatus), .outIndex(outIndex)
  );

  function automatic logic [63:0] bMask(input int i);
    logic [63:0] t [8];
    t[0] = 64'hF00FE11E_C33C0FF7; t[1] = 64'h00FF00FF_00FFF0FF;
    t[2] = 64'h0F0F0F0F_0F0FFF00; t[3] = 64'h11113333_7777000F;
    t[4] = 64'h22224444_8888222F; t[5] = 64'h44448888_FFFF4441;
    t[6] = 64'h8888FFFF_11118882; t[7] = 64'hFFFF1111_22221114;
    return t[i];
  endfunction

  function automatic logic [7:0] bEncode(input logic [63:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = ^(d & bMask(i));
    return r;
  endfunction

  function automatic logic [7:0] bCol(input int b);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) c[i] = bMask(i) >> b;
    return c;
  endfunction

  task automatic predict(input logic [63:0] d, input logic [7:0] c,
                         output logic [1:0] st, output logic [5:0] ix,
                         output logic [63:0] od, output logic [7:0] oc);
    logic [7:0] s;
    int hit;
    s = bEncode(d) ^ c;
    st = 2'd0; ix = '0; od = d; oc = c; hit = -1;
    for (int b = 63; b >= 0; b--) if (s == bCol(b)) hit = b;
    if (s == 8'd0) st = 2'd0;
    else if (hit >= 0) begin st = 2'd1; ix = 6'(hit); od[hit] = ~d[hit]; end
    else if ($countones(s) == 1) begin
      st = 2'd2;
      for (int j = 7; j >= 0; j--) if (s[j]) ix = 6'(j);
      oc[ix[2:0]] = ~c[ix[2:0]];
    end else st = 2'd3;
  endtask

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runVec(input string req, input logic [63:0] d, input logic [7:0] c);
    logic [1:0] st; logic [5:0] ix; logic [63:0] od; logic [7:0] oc;
    inData = d; inCheck = c; inValid = 1'b1;
    @(negedge clk);
    predict(d, c, st, ix, od, oc);
    check64({req, " status"}, 64'(outStatus), 64'(st));
    check64({req, " index"},  64'(outIndex),  64'(ix));
    check64({req, " data"},   outData,        od);
    check64({req, " check"},  64'(outCheck),  64'(oc));
    check64({req, " valid"},  64'(outValid),  64'd1);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  c;
    void'($urandom(32'h5ECD));
    rstN = 1'b0; inValid = 1'b1; inData = '1; inCheck = '0;
    repeat (3) @(negedge clk);
    // R7: reset holds valid and status low
    check64("R7 reset valid", 64'(outValid), 64'd0);
    check64("R7 reset status", 64'(outStatus), 64'd0);
    rstN = 1'b1; inValid = 1'b0;
    @(negedge clk);

    // R1 R4: clean codewords, directed and random
    runVec("R4 zero word", 64'd0, bEncode(64'd0));
    runVec("R4 ones word", '1, bEncode('1));
    for (int n = 0; n < 20; n++) begin
      d = {$urandom, $urandom};
      runVec("R1 clean", d, bEncode(d));
    end

    // R2: every data bit flipped
    for (int b = 0; b < 64; b++) begin
      d = {$urandom, $urandom};
      c = bEncode(d);
      d[b] = ~d[b];
      runVec("R2 data flip", d, c);
    end

    // R3: every check bit flipped
    for (int j = 0; j < 8; j++) begin
      d = {$urandom, $urandom};
      c = bEncode(d);
      c[j] = ~c[j];
      runVec("R3 check flip", d, c);
    end

    // R5: two check bits flipped, directed
    d = 64'h0123_4567_89AB_CDEF;
    runVec("R5 two check bits", d, bEncode(d) ^ 8'h81);

    // R6: random double flips over the whole 72-bit codeword
    for (int n = 0; n < 200; n++) begin
      int p, q;
      logic [71:0] cw;
      d = {$urandom, $urandom};
      cw = {bEncode(d), d};
      p = $urandom_range(71, 0);
      q = $urandom_range(70, 0);
      if (q >= p) q++;
      cw[p] = ~cw[p];
      cw[q] = ~cw[q];
      runVec("R6 double flip", cw[63:0], cw[71:64]);
    end

    // R5: raw random check bytes
    for (int n = 0; n < 30; n++) runVec("R5 raw", {$urandom, $urandom}, 8'($urandom));

    // R7: valid drops one clock after inValid drops
    inValid = 1'b0;
    @(negedge clk);
    check64("R7 valid drop", 64'(outValid), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule